// File: doc/BRIEF.md
# Multi-Step Instruction Sequencer

This block executes a small 32-bit load/store instruction subset one instruction at a time. Each instruction moves through a fixed chain of steps (fetch, decode with register read, execute, memory access, writeback), one step per clock. It stops after the last step its class needs, so a load takes five clocks, a store or a register-to-register operation four, and a conditional branch three. Instructions never overlap. The core holds the program counter, a 32-entry register file, an ALU, a sign extender and two separate word memories, one for instructions and one for data.

Both memories are filled through a word-wide preload port. This normally happens while reset is held. After reset is released, the core starts fetching from address zero. Observation outputs show the current step, a pulse in the final step of every instruction, the program counter, and the register-file and data-memory write strobes with their address and data.

Top module: `stepped_exec_core`

## Requirements
- R1: While reset is asserted, and until the internal two-stage reset release completes, step_o is 0, pc_o is 0, and retire_o, rf_we_o and dm_we_o are all 0. The first fetch step follows that release.
- R2: step_o encodes fetch=0, decode=1, execute=2, memory=3, writeback=4. A load walks through 0,1,2,3,4. A store walks through 0,1,2,3. A register operation walks through 0,1,2,4. A branch walks through 0,1,2. retire_o is high only in the final step.
- R3: The opcode is bits [31:26], with register op 0x00, branch 0x04, load 0x23 and store 0x2B. The first source is bits [25:20+1] (that is, [25:21]), the second source is bits [20:16], the register-op destination is bits [15:11] and the immediate is bits [15:0]. A load writes the register named in bits [20:16].
- R4: A register op picks its function from bits [5:0]: 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x2A signed set-less-than (result 1 or 0). The result is written to the destination register.
- R5: A load writes into its target register the data word at byte address (first source + sign-extended immediate). The word is chosen by address bits [7:2] for a 64-word memory.
- R6: A store writes the second source register to the data word at (first source + sign-extended immediate). dm_we_o, dm_addr_o and dm_wdata_o show this write during the memory step of a store and at no other time.
- R7: rf_we_o is high only in the writeback step. In that step rf_waddr_o and rf_wdata_o carry the destination register and the value written (memory data for a load, ALU result for a register op).
- R8: Register 0 always reads as zero, and writes to it have no effect.
- R9: A branch compares its two source registers. If they are equal, the PC becomes PC+4 plus the sign-extended immediate shifted left by two; otherwise it becomes PC+4. Every other instruction advances the PC by 4. The PC changes only at the end of an instruction's final step and is stable otherwise.
- R10: After every final step the next step is fetch.
- R11: When ld_we is high at a clock edge, ld_data is written to word ld_addr of the instruction memory (ld_dmem=0) or of the data memory (ld_dmem=1). This works while reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ld_we | input | 1 | Preload write strobe |
| ld_dmem | input | 1 | Preload target: 0 instruction memory, 1 data memory |
| ld_addr | input | LD_AW | Preload word index |
| ld_data | input | 32 | Preload word |
| step_o | output | 3 | Current step code |
| retire_o | output | 1 | High in the final step of each instruction |
| pc_o | output | 32 | Program counter |
| rf_we_o | output | 1 | Register-file write strobe |
| rf_waddr_o | output | 5 | Register being written |
| rf_wdata_o | output | 32 | Value being written to the register |
| dm_we_o | output | 1 | Data-memory write strobe from a store |
| dm_addr_o | output | 32 | Byte address of the store |
| dm_wdata_o | output | 32 | Store data |

## Verification
The bench builds the core with its default parameters: 64-word instruction and data memories and two reset-release stages. With these sizes the bench can preload every data word and initialise all 31 writable registers from memory. It then runs a program of register initialisation, directed cases and a random tail from its fixed seed. The directed cases cover a negative load offset, writes to register 0, a store followed by a load of the same word, and a taken branch that skips an instruction. Forward-only random branches stay inside the 64-word program space, so every path ends at the same halt address. Every step of every instruction is compared against a reference model inside the bench.

// File: rtl/sxc_pkg.sv
package sxc_pkg;

  localparam int XLEN   = 32;
  localparam int NREG   = 32;
  localparam int RIDX_W = $clog2(NREG);

  typedef enum logic [2:0] {
    ST_FETCH  = 3'd0,
    ST_DECODE = 3'd1,
    ST_EXEC   = 3'd2,
    ST_MEM    = 3'd3,
    ST_WB     = 3'd4
  } step_e;

  typedef enum logic [2:0] {
    CL_LOAD,
    CL_STORE,
    CL_ALU,
    CL_BRANCH,
    CL_NOP
  } iclass_e;

  typedef enum logic [2:0] {
    AOP_ADD,
    AOP_SUB,
    AOP_AND,
    AOP_OR,
    AOP_SLT,
    AOP_ZERO
  } aluop_e;

  localparam logic [5:0] OPC_ALU   = 6'h00;
  localparam logic [5:0] OPC_BEQ   = 6'h04;
  localparam logic [5:0] OPC_LOAD  = 6'h23;
  localparam logic [5:0] OPC_STORE = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef struct packed {
    iclass_e cls;
    aluop_e  op;
    logic    use_imm;
    logic    dst_rd;
    logic    wb_mem;
    logic    is_branch;
  } dec_t;

  function automatic dec_t decode_instr(input logic [XLEN-1:0] ins);
    dec_t d;
    d.cls       = CL_NOP;
    d.op        = AOP_ZERO;
    d.use_imm   = 1'b0;
    d.dst_rd    = 1'b0;
    d.wb_mem    = 1'b0;
    d.is_branch = 1'b0;
    unique case (ins[31:26])
      OPC_LOAD: begin
        d.cls     = CL_LOAD;
        d.op      = AOP_ADD;
        d.use_imm = 1'b1;
        d.wb_mem  = 1'b1;
      end
      OPC_STORE: begin
        d.cls     = CL_STORE;
        d.op      = AOP_ADD;
        d.use_imm = 1'b1;
      end
      OPC_BEQ: begin
        d.cls       = CL_BRANCH;
        d.op        = AOP_SUB;
        d.is_branch = 1'b1;
      end
      OPC_ALU: begin
        d.cls    = CL_ALU;
        d.dst_rd = 1'b1;
        unique case (ins[5:0])
          FN_ADD:  d.op = AOP_ADD;
          FN_SUB:  d.op = AOP_SUB;
          FN_AND:  d.op = AOP_AND;
          FN_OR:   d.op = AOP_OR;
          FN_SLT:  d.op = AOP_SLT;
          default: d.op = AOP_ZERO;
        endcase
      end
      default: d.cls = CL_NOP;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/sxc_alu.sv
module sxc_alu
  import sxc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  aluop_e       op,
  output logic [W-1:0] res,
  output logic         is_zero
);

  logic [W-1:0] diff;

  assign diff = opa - opb;

  always_comb begin
    unique case (op)
      AOP_ADD: res = opa + opb;
      AOP_SUB: res = diff;
      AOP_AND: res = opa & opb;
      AOP_OR:  res = opa | opb;
      AOP_SLT: res = {{(W-1){1'b0}}, ($signed(opa) < $signed(opb))};
      default: res = '0;
    endcase
  end

  assign is_zero = (res == '0);

endmodule

// File: rtl/sxc_regfile.sv
module sxc_regfile #(
  parameter int NUM = 32,
  parameter int W   = 32,
  localparam int AW = $clog2(NUM)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [W-1:0]  wr_val,
  input  logic [AW-1:0] rd_idx_a,
  input  logic [AW-1:0] rd_idx_b,
  output logic [W-1:0]  rd_val_a,
  output logic [W-1:0]  rd_val_b
);

  logic [W-1:0] cells [NUM];

  // entry 0 is never written; reads of index 0 are forced to zero
  always_ff @(posedge clk) begin
    if (wr_en && (wr_idx != '0)) begin
      cells[wr_idx] <= wr_val;
    end
  end

  assign rd_val_a = (rd_idx_a == '0) ? '0 : cells[rd_idx_a];
  assign rd_val_b = (rd_idx_b == '0) ? '0 : cells[rd_idx_b];

endmodule

// File: rtl/sxc_wordmem.sv
module sxc_wordmem #(
  parameter int DEPTH = 64,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [W-1:0]  wr_val,
  input  logic [AW-1:0] rd_idx,
  output logic [W-1:0]  rd_val
);

  logic [W-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      words[wr_idx] <= wr_val;
    end
  end

  assign rd_val = words[rd_idx];

endmodule

// File: rtl/sxc_seq_ctrl.sv
module sxc_seq_ctrl
  import sxc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XLEN-1:0] instr,
  output step_e           step,
  output dec_t            dec,
  output logic            ir_en,
  output logic            opnd_en,
  output logic            alu_en,
  output logic            mdr_en,
  output logic            dm_we,
  output logic            rf_we,
  output logic            retire
);

  step_e step_q;
  step_e step_d;

  assign dec  = decode_instr(instr);
  assign step = step_q;

  always_comb begin
    step_d  = step_q;
    ir_en   = 1'b0;
    opnd_en = 1'b0;
    alu_en  = 1'b0;
    mdr_en  = 1'b0;
    dm_we   = 1'b0;
    rf_we   = 1'b0;
    retire  = 1'b0;
    unique case (step_q)
      ST_FETCH: begin
        ir_en  = 1'b1;
        step_d = ST_DECODE;
      end
      ST_DECODE: begin
        opnd_en = 1'b1;
        step_d  = ST_EXEC;
      end
      ST_EXEC: begin
        alu_en = 1'b1;
        unique case (dec.cls)
          CL_LOAD, CL_STORE: step_d = ST_MEM;
          CL_ALU:            step_d = ST_WB;
          default: begin
            retire = 1'b1;
            step_d = ST_FETCH;
          end
        endcase
      end
      ST_MEM: begin
        mdr_en = 1'b1;
        if (dec.cls == CL_STORE) begin
          dm_we  = 1'b1;
          retire = 1'b1;
          step_d = ST_FETCH;
        end else begin
          step_d = ST_WB;
        end
      end
      ST_WB: begin
        rf_we  = 1'b1;
        retire = 1'b1;
        step_d = ST_FETCH;
      end
      default: step_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= ST_FETCH;
    end else begin
      step_q <= step_d;
    end
  end

endmodule

// File: rtl/stepped_exec_core.sv
module stepped_exec_core
  import sxc_pkg::*;
#(
  parameter int IMEM_WORDS  = 64,
  parameter int DMEM_WORDS  = 64,
  parameter int SYNC_STAGES = 2,
  localparam int IM_AW = $clog2(IMEM_WORDS),
  localparam int DM_AW = $clog2(DMEM_WORDS),
  localparam int LD_AW = (IM_AW > DM_AW) ? IM_AW : DM_AW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_we,
  input  logic             ld_dmem,
  input  logic [LD_AW-1:0] ld_addr,
  input  logic [31:0]      ld_data,
  output logic [2:0]       step_o,
  output logic             retire_o,
  output logic [31:0]      pc_o,
  output logic             rf_we_o,
  output logic [4:0]       rf_waddr_o,
  output logic [31:0]      rf_wdata_o,
  output logic             dm_we_o,
  output logic [31:0]      dm_addr_o,
  output logic [31:0]      dm_wdata_o
);

  // ---------------- reset release ----------------
  logic rst_sync_n;

  generate
    if (SYNC_STAGES > 1) begin : g_sync_chain
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sync_q <= '0;
        end else begin
          sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
        end
      end
      assign rst_sync_n = sync_q[SYNC_STAGES-1];
    end else begin : g_sync_single
      logic sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sync_q <= 1'b0;
        end else begin
          sync_q <= 1'b1;
        end
      end
      assign rst_sync_n = sync_q;
    end
  endgenerate

  // ---------------- state ----------------
  logic [XLEN-1:0] pc_q, pc_d;
  logic [XLEN-1:0] ir_q, opa_q, opb_q, alu_q, mdr_q;

  step_e step;
  dec_t  dec;
  logic  ir_en, opnd_en, alu_en, mdr_en, core_dm_we, core_rf_we, retire;

  sxc_seq_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .instr   (ir_q),
    .step    (step),
    .dec     (dec),
    .ir_en   (ir_en),
    .opnd_en (opnd_en),
    .alu_en  (alu_en),
    .mdr_en  (mdr_en),
    .dm_we   (core_dm_we),
    .rf_we   (core_rf_we),
    .retire  (retire)
  );

  // ---------------- instruction memory ----------------
  logic [XLEN-1:0] imem_rd;

  sxc_wordmem #(.DEPTH(IMEM_WORDS), .W(XLEN)) u_imem (
    .clk    (clk),
    .wr_en  (ld_we & ~ld_dmem),
    .wr_idx (ld_addr[IM_AW-1:0]),
    .wr_val (ld_data),
    .rd_idx (pc_q[IM_AW+1:2]),
    .rd_val (imem_rd)
  );

  // ---------------- register file ----------------
  logic [RIDX_W-1:0] rf_waddr;
  logic [XLEN-1:0]   rf_wdata, rf_rd_a, rf_rd_b;

  assign rf_waddr = dec.dst_rd ? ir_q[15:11] : ir_q[20:16];
  assign rf_wdata = dec.wb_mem ? mdr_q : alu_q;

  sxc_regfile #(.NUM(NREG), .W(XLEN)) u_rf (
    .clk      (clk),
    .wr_en    (core_rf_we),
    .wr_idx   (rf_waddr),
    .wr_val   (rf_wdata),
    .rd_idx_a (ir_q[25:21]),
    .rd_idx_b (ir_q[20:16]),
    .rd_val_a (rf_rd_a),
    .rd_val_b (rf_rd_b)
  );

  // ---------------- execute ----------------
  logic [XLEN-1:0] imm_sx, alu_b, alu_y, pc_plus4, br_target;
  logic            alu_zero;

  assign imm_sx = {{(XLEN-16){ir_q[15]}}, ir_q[15:0]};
  assign alu_b  = dec.use_imm ? imm_sx : opb_q;

  sxc_alu #(.W(XLEN)) u_alu (
    .opa     (opa_q),
    .opb     (alu_b),
    .op      (dec.op),
    .res     (alu_y),
    .is_zero (alu_zero)
  );

  assign pc_plus4  = pc_q + XLEN'(4);
  assign br_target = pc_plus4 + {imm_sx[XLEN-3:0], 2'b00};
  assign pc_d      = (dec.is_branch && alu_zero) ? br_target : pc_plus4;

  // ---------------- data memory ----------------
  logic             dm_wr_en;
  logic [DM_AW-1:0] dm_wr_idx;
  logic [XLEN-1:0]  dm_wr_val, dmem_rd;

  // preload has priority over a store in the same cycle
  always_comb begin
    if (ld_we && ld_dmem) begin
      dm_wr_en  = 1'b1;
      dm_wr_idx = ld_addr[DM_AW-1:0];
      dm_wr_val = ld_data;
    end else begin
      dm_wr_en  = core_dm_we;
      dm_wr_idx = alu_q[DM_AW+1:2];
      dm_wr_val = opb_q;
    end
  end

  sxc_wordmem #(.DEPTH(DMEM_WORDS), .W(XLEN)) u_dmem (
    .clk    (clk),
    .wr_en  (dm_wr_en),
    .wr_idx (dm_wr_idx),
    .wr_val (dm_wr_val),
    .rd_idx (alu_q[DM_AW+1:2]),
    .rd_val (dmem_rd)
  );

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pc_q <= '0;
    end else if (retire) begin
      pc_q <= pc_d;
    end
  end

  always_ff @(posedge clk) begin
    if (ir_en) begin
      ir_q <= imem_rd;
    end
  end

  always_ff @(posedge clk) begin
    if (opnd_en) begin
      opa_q <= rf_rd_a;
      opb_q <= rf_rd_b;
    end
  end

  always_ff @(posedge clk) begin
    if (alu_en) begin
      alu_q <= alu_y;
    end
  end

  always_ff @(posedge clk) begin
    if (mdr_en) begin
      mdr_q <= dmem_rd;
    end
  end

  logic unused_addr_bits;
  assign unused_addr_bits = ^{pc_q[1:0], pc_q[XLEN-1:IM_AW+2], alu_q[1:0], alu_q[XLEN-1:DM_AW+2]};

  // ---------------- outputs ----------------
  assign step_o     = step;
  assign retire_o   = retire;
  assign pc_o       = pc_q;
  assign rf_we_o    = core_rf_we;
  assign rf_waddr_o = rf_waddr;
  assign rf_wdata_o = rf_wdata;
  assign dm_we_o    = core_dm_we;
  assign dm_addr_o  = alu_q;
  assign dm_wdata_o = opb_q;

endmodule

// File: rtl/stepped_exec_core_chk.sv
module stepped_exec_core_chk (
  input logic        clk,
  input logic        rst_sync_n,
  input logic [2:0]  step_o,
  input logic        retire_o,
  input logic [31:0] pc_o,
  input logic        rf_we_o,
  input logic        dm_we_o
);

  // R7: register writes happen only in writeback
  assert_rf_we_in_wb_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rf_we_o |-> (step_o == 3'd4));

  // R6: data writes happen only in the memory step
  assert_dm_we_in_mem_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dm_we_o |-> (step_o == 3'd3));

  // R6 R7: never both memories in one step
  assert_one_write_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({rf_we_o, dm_we_o}));

  // R10: the step after a final step is fetch
  assert_back_to_fetch_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    retire_o |=> (step_o == 3'd0));

  // R2: fetch is always followed by decode, decode by execute
  assert_fetch_then_decode_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (step_o == 3'd0) |=> (step_o == 3'd1));
  assert_decode_then_exec_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (step_o == 3'd1) |=> (step_o == 3'd2));

  // R2: step code stays within the five defined values
  assert_step_range_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    step_o <= 3'd4);

  // R9: PC holds while an instruction is in flight
  assert_pc_hold_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !retire_o |=> $stable(pc_o));

  // R9: non-branch instructions (retiring after execute) advance by 4
  assert_pc_step_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (retire_o && (step_o != 3'd2)) |=> (pc_o == $past(pc_o) + 32'd4));

endmodule

bind stepped_exec_core stepped_exec_core_chk u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .step_o     (step_o),
  .retire_o   (retire_o),
  .pc_o       (pc_o),
  .rf_we_o    (rf_we_o),
  .dm_we_o    (dm_we_o)
);

// File: tb/stepped_exec_core_test.sv
module stepped_exec_core_test;

  localparam int CLK_PERIOD = 10;
  localparam int WORDS      = 64;
  localparam int HALT_IDX   = 61;
  localparam int WATCHDOG   = 20000;

  logic        clk;
  logic        rst_n;
  logic        ld_we;
  logic        ld_dmem;
  logic [5:0]  ld_addr;
  logic [31:0] ld_data;
  logic [2:0]  step_o;
  logic        retire_o;
  logic [31:0] pc_o;
  logic        rf_we_o;
  logic [4:0]  rf_waddr_o;
  logic [31:0] rf_wdata_o;
  logic        dm_we_o;
  logic [31:0] dm_addr_o;
  logic [31:0] dm_wdata_o;

  stepped_exec_core uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .ld_we      (ld_we),
    .ld_dmem    (ld_dmem),
    .ld_addr    (ld_addr),
    .ld_data    (ld_data),
    .step_o     (step_o),
    .retire_o   (retire_o),
    .pc_o       (pc_o),
    .rf_we_o    (rf_we_o),
    .rf_waddr_o (rf_waddr_o),
    .rf_wdata_o (rf_wdata_o),
    .dm_we_o    (dm_we_o),
    .dm_addr_o  (dm_addr_o),
    .dm_wdata_o (dm_wdata_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int nchk = 0;
  int nerr = 0;

  logic [31:0] prog [WORDS];
  logic [31:0] m_dm [WORDS];
  logic [31:0] m_rf [32];
  logic [31:0] m_pc;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  function automatic logic [31:0] ref_alu(input logic [5:0] fn, input logic [31:0] a, input logic [31:0] b);
    case (fn)
      6'h20:   return a + b;
      6'h22:   return a - b;
      6'h24:   return a & b;
      6'h25:   return a | b;
      6'h2A:   return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  // number of steps per opcode class
  function automatic int steps_of(input logic [5:0] op);
    case (op)
      6'h23:   return 5;
      6'h2B:   return 4;
      6'h00:   return 4;
      default: return 3;
    endcase
  endfunction

  function automatic logic [2:0] step_at(input logic [5:0] op, input int k);
    if (op == 6'h00 && k == 3) return 3'd4;
    return 3'(k);
  endfunction

  function automatic logic [31:0] rand_instr(input int idx);
    int sel, rs, rt, rd, maxoff, off;
    logic [5:0] fns [5];
    fns[0] = 6'h20; fns[1] = 6'h22; fns[2] = 6'h24; fns[3] = 6'h25; fns[4] = 6'h2A;
    sel = int'($urandom % 7);
    rs  = int'($urandom % 32);
    rt  = int'($urandom % 32);
    rd  = int'($urandom % 32);
    if (sel < 4) return enc_r(rs, rt, rd, fns[$urandom % 5]);
    if (sel == 4) return enc_i(6'h23, 0, rt, 16'(4 * ($urandom % 64)));
    if (sel == 5) return enc_i(6'h2B, 0, rt, 16'(4 * ($urandom % 64)));
    maxoff = (HALT_IDX - 1) - idx;
    if (maxoff > 3) maxoff = 3;
    off = int'($urandom % (maxoff + 1));
    if ($urandom % 2 == 0) rt = rs;
    return enc_i(6'h04, rs, rt, 16'(off));
  endfunction

  initial begin
    int unsigned seed_val;
    int k;
    int cyc;
    bit done;
    logic [31:0] ins, va, vb, sx, exp_val, exp_addr, exp_npc;
    logic [5:0]  op;
    int          rs, rt, dest, nst, idx;
    logic [2:0]  exp_step;
    bit          last, exp_dmwe;
    string       tag;

    seed_val = $urandom(32'h5EED_0007);
    rst_n   = 1'b0;
    ld_we   = 1'b0;
    ld_dmem = 1'b0;
    ld_addr = '0;
    ld_data = '0;

    // ---- build program ----
    for (int i = 0; i < WORDS; i++) prog[i] = 32'd0;
    for (int i = 0; i < 31; i++) prog[i] = enc_i(6'h23, 0, i + 1, 16'(4 * (i + 1)));
    prog[31] = enc_i(6'h23, 0, 1, 16'h0000);          // r1 <- 0xF0
    prog[32] = enc_i(6'h23, 1, 2, 16'hFFF0);          // negative offset: word 56
    prog[33] = enc_r(1, 2, 0, 6'h20);                 // write to r0, dropped
    prog[34] = enc_r(0, 0, 3, 6'h25);                 // r3 <- r0 | r0 = 0
    prog[35] = enc_i(6'h2B, 0, 2, 16'd8);             // store r2 to word 2
    prog[36] = enc_i(6'h23, 0, 4, 16'd8);             // reload it into r4
    prog[37] = enc_i(6'h04, 4, 2, 16'd1);             // taken, skips 38
    prog[38] = enc_r(1, 1, 5, 6'h20);
    prog[39] = enc_i(6'h04, 1, 2, 16'd1);
    for (int i = 40; i < HALT_IDX; i++) prog[i] = rand_instr(i);
    prog[HALT_IDX] = enc_i(6'h04, 0, 0, 16'hFFFF);

    for (int i = 0; i < WORDS; i++) m_dm[i] = $urandom;
    m_dm[0] = 32'h0000_00F0;
    for (int i = 0; i < 32; i++) m_rf[i] = 32'd0;
    m_pc = 32'd0;

    // ---- R1: state under reset ----
    repeat (2) @(negedge clk);
    chk(step_o == 3'd0, "R1 step", 32'(step_o), 32'd0);
    chk(pc_o == 32'd0, "R1 pc", pc_o, 32'd0);
    chk(retire_o == 1'b0, "R1 retire", 32'(retire_o), 32'd0);
    chk(rf_we_o == 1'b0 && dm_we_o == 1'b0, "R1 writes", 32'({rf_we_o, dm_we_o}), 32'd0);

    // ---- R11: preload both memories while held in reset ----
    for (int i = 0; i < WORDS; i++) begin
      ld_we = 1'b1; ld_dmem = 1'b0; ld_addr = 6'(i); ld_data = prog[i];
      @(negedge clk);
    end
    for (int i = 0; i < WORDS; i++) begin
      ld_we = 1'b1; ld_dmem = 1'b1; ld_addr = 6'(i); ld_data = m_dm[i];
      @(negedge clk);
    end
    ld_we = 1'b0;
    chk(step_o == 3'd0 && pc_o == 32'd0, "R1 after preload", pc_o, 32'd0);

    // ---- release reset, wait for the internal release ----
    rst_n = 1'b1;
    @(posedge clk);
    chk(retire_o == 1'b0 && step_o == 3'd0, "R1 release", 32'(step_o), 32'd0);
    @(posedge clk);

    // ---- run and compare every step ----
    k = 0; cyc = 0; done = 1'b0;
    ins = '0; op = '0; nst = 3; dest = 0; exp_val = '0; exp_addr = '0; exp_npc = '0;
    rs = 0; rt = 0; va = '0; vb = '0; sx = '0; idx = 0;
    while (!done) begin
      @(negedge clk);
      cyc++;
      if (cyc > WATCHDOG) begin
        chk(1'b0, "watchdog", 32'(cyc), 32'(WATCHDOG));
        break;
      end
      if (k == 0) begin
        idx  = int'(m_pc >> 2);
        ins  = prog[idx % WORDS];
        op   = ins[31:26];
        rs   = int'(ins[25:21]);
        rt   = int'(ins[20:16]);
        va   = m_rf[rs];
        vb   = m_rf[rt];
        sx   = {{16{ins[15]}}, ins[15:0]};
        nst  = steps_of(op);
        exp_npc  = m_pc + 32'd4;
        exp_addr = va + sx;
        dest     = 0;
        exp_val  = '0;
        case (op)
          6'h00: begin dest = int'(ins[15:11]); exp_val = ref_alu(ins[5:0], va, vb); end
          6'h23: begin dest = rt; exp_val = m_dm[exp_addr[7:2]]; end
          6'h04: if (va == vb) exp_npc = m_pc + 32'd4 + {sx[29:0], 2'b00};
          default: ;
        endcase
      end

      chk(pc_o == m_pc, "R9 pc", pc_o, m_pc);
      exp_step = step_at(op, k);
      chk(step_o == exp_step, (k == 0) ? "R10 step" : "R2 step", 32'(step_o), 32'(exp_step));
      last = (k == nst - 1);
      chk(retire_o == last, "R2 retire", 32'(retire_o), 32'(last));

      chk(rf_we_o == (exp_step == 3'd4), "R7 rf_we", 32'(rf_we_o), 32'(exp_step == 3'd4));
      if (exp_step == 3'd4 && rf_we_o) begin
        chk(rf_waddr_o == 5'(dest), "R3 dest", 32'(rf_waddr_o), 32'(dest));
        if (op == 6'h23) tag = (idx < 31) ? "R11 load" : "R5 load";
        else tag = (rs == 0 || rt == 0 || dest == 0) ? "R8 op" : "R4 op";
        chk(rf_wdata_o == exp_val, tag, rf_wdata_o, exp_val);
      end

      exp_dmwe = (op == 6'h2B) && (k == 3);
      chk(dm_we_o == exp_dmwe, "R6 dm_we", 32'(dm_we_o), 32'(exp_dmwe));
      if (exp_dmwe && dm_we_o) begin
        chk(dm_addr_o == exp_addr, "R6 addr", dm_addr_o, exp_addr);
        chk(dm_wdata_o == vb, "R6 data", dm_wdata_o, vb);
      end

      if (last) begin
        if ((op == 6'h00 || op == 6'h23) && dest != 0) m_rf[dest] = exp_val;
        if (op == 6'h2B) m_dm[exp_addr[7:2]] = vb;
        m_pc = exp_npc;
        k = 0;
        if (m_pc == 32'(HALT_IDX * 4)) done = 1'b1;
      end else begin
        k++;
      end
    end

    @(negedge clk);
    chk(pc_o == m_pc, "R9 final pc", pc_o, m_pc);
    chk(step_o == 3'd0, "R10 final step", 32'(step_o), 32'd0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule